// File: doc/BRIEF.md
# Radix-4 Butterfly with Embedded Twiddle Factors

This block performs one radix-4 decimation butterfly on four complex samples a, b, c and d. Each sample is a pair of 16-bit two's-complement words. The four butterfly sums are formed as follows:

- The quarter-turn rotations by +j and -j are done by exchanging the real and imaginary parts and negating one of them. No multiplier is used for them.
- Each of the two adder levels halves its result with an arithmetic shift, so the sums can never overflow.
- Outputs y1, y2 and y3 are then multiplied by a twiddle factor taken from a small constant table of Q1.15 values for a 16-point transform.

A 2-bit group selector chooses the twiddle set. Output y_m uses the table entry at index m·g. Output y0 is never multiplied.

The block is fully pipelined. It accepts a new butterfly on every clock cycle, and each result appears a fixed three cycles after its input. A status line goes high together with any result in which a twiddle product had to be clipped to the 16-bit range. A controller that sequences the stages of a 16-point transform feeds the block, reorders the samples and chooses the group index.

Top module: `radix4_bfly`

## Requirements
- R1: y0 = ((a+c)/2 + (b+d)/2)/2 per component, where every /2 is an arithmetic right shift (floor). y0 is never multiplied by a twiddle factor.
- R2: Before twiddling, y2 = ((a+c)/2 − (b+d)/2)/2 per component, with floor halving.
- R3: With s1 = (a−c)/2 and s3 = (b−d)/2, the untwiddled outputs are built by rotation, without a multiplier:
  - y1 = (s1.re + s3.im, s1.im − s3.re)/2
  - y3 = (s1.re − s3.im, s1.im + s3.re)/2
  - Each halving is a floor shift.
- R4: The adder levels never overflow, for any inputs including full-scale −32768 and 32767, because each level works on 17 bits before it halves.
- R5: Twiddle factors:
  - For m = 1..3, y_m is multiplied by W[k] with k = m·g, where g is `in_grp` (0..3). When k = 0 the value passes through unchanged.
  - The table (re, im) for k = 0..9 is: (32767,0), (30274,−12540), (23170,−23170), (12540,−30274), (0,−32767), (−12540,−30274), (−23170,−23170), (−30274,−12540), (−32767,0), (−30274,12540).
  - Each product component is (xr·wr − xi·wi) or (xr·wi + xi·wr), arithmetically shifted right by 15.
- R6: A product component above 32767 is clipped to 32767, and one below −32768 is clipped to −32768. `ovfl` is high in the cycle whose outputs contain a clipped component, and low otherwise.
- R7: The result of a butterfly presented with `in_valid` high at a rising edge appears on the outputs, with `out_valid` high, after exactly three rising edges. A new butterfly may be presented every cycle.
- R8: While `rst_n` is low at a rising edge, the following edge leaves `out_valid` low, `ovfl` low and all outputs zero.
- R9: Inputs presented with `in_valid` low produce `out_valid` low and `ovfl` low three cycles later, even if those inputs would have saturated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | The four input samples are valid this cycle |
| in_grp | input | 2 | Group selector g for the twiddle index m·g |
| a_re | input | 16 | Sample a, real part |
| a_im | input | 16 | Sample a, imaginary part |
| b_re | input | 16 | Sample b, real part |
| b_im | input | 16 | Sample b, imaginary part |
| c_re | input | 16 | Sample c, real part |
| c_im | input | 16 | Sample c, imaginary part |
| d_re | input | 16 | Sample d, real part |
| d_im | input | 16 | Sample d, imaginary part |
| out_valid | output | 1 | Outputs carry a butterfly result |
| y0_re | output | 16 | Output 0, real part |
| y0_im | output | 16 | Output 0, imaginary part |
| y1_re | output | 16 | Output 1, real part |
| y1_im | output | 16 | Output 1, imaginary part |
| y2_re | output | 16 | Output 2, real part |
| y2_im | output | 16 | Output 2, imaginary part |
| y3_re | output | 16 | Output 3, real part |
| y3_im | output | 16 | Output 3, imaginary part |
| ovfl | output | 1 | A twiddle product of this result was clipped |

## Verification
The bench targets several corner cases:

- **Full-scale inputs.** A design that halves after a 16-bit add would wrap, and the sums would change sign.
- **Odd negative values.** These expose a halving that rounds toward zero instead of flooring.
- **Samples on b alone.** These reveal a ±j rotation with the wrong sign or swapped parts, because y1 and y3 would be exchanged.
- **Saturation vector.** A vector built so that one product exceeds the range is sent with group 2 and again with group 0. A design that clips wrongly or flags overflow on pass-through would be caught.
- **Invalid cycle with the saturating vector.** This catches an overflow line that ignores `in_valid`.
- **Back-to-back streaming and a mid-stream reset.** These catch a latency off by one and a pipeline that keeps stale valid bits.

// File: rtl/bfly_pkg.sv
// Package: shared widths, the complex sample type and the halving adders.
// Assumes: two's-complement data of DW bits; halving rounds toward minus infinity.
package bfly_pkg;
    localparam int DW = 16;            // data word width
    localparam int GW = 2;             // group selector width
    localparam int NOUT = 4;           // butterfly radix
    localparam int KW = 4;             // twiddle index width, holds (NOUT-1)*(2**GW-1)
    localparam int NTW = (NOUT - 1) * (2**GW - 1) + 1;  // table entries used

    typedef struct packed {
        logic signed [DW-1:0] re;
        logic signed [DW-1:0] im;
    } cplx_t;

    // Sum of two words on DW+1 bits, halved with an arithmetic shift.
    function automatic logic signed [DW-1:0] half_add(input logic signed [DW-1:0] x,
                                                     input logic signed [DW-1:0] y);
        logic [DW:0] t;
        t = {x[DW-1], x} + {y[DW-1], y};
        return t[DW:1];
    endfunction

    // Difference of two words on DW+1 bits, halved with an arithmetic shift.
    function automatic logic signed [DW-1:0] half_sub(input logic signed [DW-1:0] x,
                                                     input logic signed [DW-1:0] y);
        logic [DW:0] t;
        t = {x[DW-1], x} - {y[DW-1], y};
        return t[DW:1];
    endfunction
endpackage

// File: rtl/bfly_presum.sv
// Module: first adder level of the butterfly.
// Forms halved sums and differences of the (a,c) and (b,d) pairs and registers
// them together with the valid bit and group selector.
// Assumes: inputs stable around the rising edge; no overflow is possible.
module bfly_presum
    import bfly_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vin,
    input  logic [GW-1:0] gin,
    input  cplx_t         a,
    input  cplx_t         b,
    input  cplx_t         c,
    input  cplx_t         d,
    output logic          vout,
    output logic [GW-1:0] gout,
    output cplx_t         sac_p,
    output cplx_t         sac_m,
    output cplx_t         sbd_p,
    output cplx_t         sbd_m
);
    // Register the four pair sums and the control side-band.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vout  <= 1'b0;
            gout  <= '0;
            sac_p <= '0;
            sac_m <= '0;
            sbd_p <= '0;
            sbd_m <= '0;
        end else begin
            vout     <= vin;
            gout     <= gin;
            sac_p.re <= half_add(a.re, c.re);
            sac_p.im <= half_add(a.im, c.im);
            sac_m.re <= half_sub(a.re, c.re);
            sac_m.im <= half_sub(a.im, c.im);
            sbd_p.re <= half_add(b.re, d.re);
            sbd_p.im <= half_add(b.im, d.im);
            sbd_m.re <= half_sub(b.re, d.re);
            sbd_m.im <= half_sub(b.im, d.im);
        end
    end
endmodule

// File: rtl/bfly_combine.sv
// Module: second adder level of the butterfly.
// Combines the pair sums into the four untwiddled outputs; the -j and +j
// rotations of the (b-d) term are done by exchanging parts and flipping a sign.
// Assumes: inputs come from bfly_presum; no overflow is possible.
module bfly_combine
    import bfly_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vin,
    input  logic [GW-1:0] gin,
    input  cplx_t         sac_p,
    input  cplx_t         sac_m,
    input  cplx_t         sbd_p,
    input  cplx_t         sbd_m,
    output logic          vout,
    output logic [GW-1:0] gout,
    output cplx_t         u0,
    output cplx_t         u1,
    output cplx_t         u2,
    output cplx_t         u3
);
    // Register the four combined outputs and the control side-band.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vout <= 1'b0;
            gout <= '0;
            u0   <= '0;
            u1   <= '0;
            u2   <= '0;
            u3   <= '0;
        end else begin
            vout  <= vin;
            gout  <= gin;
            u0.re <= half_add(sac_p.re, sbd_p.re);
            u0.im <= half_add(sac_p.im, sbd_p.im);
            u2.re <= half_sub(sac_p.re, sbd_p.re);
            u2.im <= half_sub(sac_p.im, sbd_p.im);
            // minus j times (b-d): (re,im) -> (im,-re)
            u1.re <= half_add(sac_m.re, sbd_m.im);
            u1.im <= half_sub(sac_m.im, sbd_m.re);
            // plus j times (b-d): (re,im) -> (-im,re)
            u3.re <= half_sub(sac_m.re, sbd_m.im);
            u3.im <= half_add(sac_m.im, sbd_m.re);
        end
    end
endmodule

// File: rtl/bfly_twiddle_rom.sv
// Module: constant table of twiddle factors exp(-j*2*pi*k/16) in Q1.15.
// The value 1.0 is represented as 32767. Indices above the used range
// return entry 0.
// Assumes: k is below NTW in normal use.
module bfly_twiddle_rom
    import bfly_pkg::*;
(
    input  logic [KW-1:0] k,
    output cplx_t         w
);
    // Look up the twiddle constant for index k.
    always_comb begin
        case (k)
            4'd1:    w = '{re:  16'sd30274, im: -16'sd12540};
            4'd2:    w = '{re:  16'sd23170, im: -16'sd23170};
            4'd3:    w = '{re:  16'sd12540, im: -16'sd30274};
            4'd4:    w = '{re:  16'sd0,     im: -16'sd32767};
            4'd5:    w = '{re: -16'sd12540, im: -16'sd30274};
            4'd6:    w = '{re: -16'sd23170, im: -16'sd23170};
            4'd7:    w = '{re: -16'sd30274, im: -16'sd12540};
            4'd8:    w = '{re: -16'sd32767, im:  16'sd0};
            4'd9:    w = '{re: -16'sd30274, im:  16'sd12540};
            default: w = '{re:  16'sd32767, im:  16'sd0};
        endcase
    end
endmodule

// File: rtl/bfly_cmul.sv
// Module: registered complex multiply by a Q1.15 twiddle with clipping.
// Each product component is shifted right by DW-1 and then clipped to DW bits.
// With bypass set, x passes through unchanged and no clip is reported.
// Assumes: w is in Q1.15.
module bfly_cmul
    import bfly_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  bypass,
    input  cplx_t x,
    input  cplx_t w,
    output cplx_t p,
    output logic  clipped
);
    localparam int PW = 2 * DW + 1;
    localparam logic signed [PW-1:0] PMAX = PW'(2**(DW-1) - 1);
    localparam logic signed [PW-1:0] PMIN = -PMAX - PW'(1);

    logic signed [PW-1:0] xr, xi, wr, wi, pre, pim, qre, qim;
    logic [DW:0] cre, cim;

    // Clip one shifted product; the top bit of the result flags a clip.
    function automatic logic [DW:0] clip(input logic signed [PW-1:0] v);
        if (v > PMAX)      return {1'b1, PMAX[DW-1:0]};
        else if (v < PMIN) return {1'b1, PMIN[DW-1:0]};
        else               return {1'b0, v[DW-1:0]};
    endfunction

    // Full-precision products, scaling shift and clipping.
    always_comb begin
        xr  = PW'(x.re);
        xi  = PW'(x.im);
        wr  = PW'(w.re);
        wi  = PW'(w.im);
        pre = xr * wr - xi * wi;
        pim = xr * wi + xi * wr;
        qre = pre >>> (DW - 1);
        qim = pim >>> (DW - 1);
        cre = clip(qre);
        cim = clip(qim);
    end

    // Register the product or the bypassed value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p       <= '0;
            clipped <= 1'b0;
        end else if (bypass) begin
            p       <= x;
            clipped <= 1'b0;
        end else begin
            p       <= {cre[DW-1:0], cim[DW-1:0]};
            clipped <= cre[DW] | cim[DW];
        end
    end
endmodule

// File: rtl/radix4_bfly.sv
// Module: pipelined radix-4 butterfly with twiddle multiply (top level).
// Pipeline: pair sums -> combine with rotations -> twiddle multiply.
// The latency is three cycles and a new input is accepted every cycle.
// ovfl is high with any result whose twiddle product was clipped.
// Assumes: synchronous active-low reset; in_grp is valid with in_valid.
module radix4_bfly
    import bfly_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [1:0]           in_grp,
    input  logic signed [15:0]   a_re,
    input  logic signed [15:0]   a_im,
    input  logic signed [15:0]   b_re,
    input  logic signed [15:0]   b_im,
    input  logic signed [15:0]   c_re,
    input  logic signed [15:0]   c_im,
    input  logic signed [15:0]   d_re,
    input  logic signed [15:0]   d_im,
    output logic                 out_valid,
    output logic signed [15:0]   y0_re,
    output logic signed [15:0]   y0_im,
    output logic signed [15:0]   y1_re,
    output logic signed [15:0]   y1_im,
    output logic signed [15:0]   y2_re,
    output logic signed [15:0]   y2_im,
    output logic signed [15:0]   y3_re,
    output logic signed [15:0]   y3_im,
    output logic                 ovfl
);
    cplx_t         a, b, c, d;
    cplx_t         sac_p, sac_m, sbd_p, sbd_m;
    cplx_t         u [NOUT];
    cplx_t         yq [NOUT];
    logic          v1, v2, v3;
    logic [GW-1:0] g1, g2;
    logic [NOUT-1:0] clip_v;

    assign a = {a_re, a_im};
    assign b = {b_re, b_im};
    assign c = {c_re, c_im};
    assign d = {d_re, d_im};

    bfly_presum u_presum (
        .clk(clk), .rst_n(rst_n), .vin(in_valid), .gin(in_grp),
        .a(a), .b(b), .c(c), .d(d),
        .vout(v1), .gout(g1),
        .sac_p(sac_p), .sac_m(sac_m), .sbd_p(sbd_p), .sbd_m(sbd_m)
    );

    bfly_combine u_combine (
        .clk(clk), .rst_n(rst_n), .vin(v1), .gin(g1),
        .sac_p(sac_p), .sac_m(sac_m), .sbd_p(sbd_p), .sbd_m(sbd_m),
        .vout(v2), .gout(g2),
        .u0(u[0]), .u1(u[1]), .u2(u[2]), .u3(u[3])
    );

    // Delay output 0 and the valid bit to line up with the multipliers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v3    <= 1'b0;
            yq[0] <= '0;
        end else begin
            v3    <= v2;
            yq[0] <= u[0];
        end
    end
    assign clip_v[0] = 1'b0;

    // One twiddle lookup and multiplier per rotated output m = 1..NOUT-1.
    for (genvar m = 1; m < NOUT; m++) begin : g_tw
        logic [KW-1:0] kidx;
        cplx_t         wv;
        assign kidx = KW'(KW'(m) * KW'(g2));
        bfly_twiddle_rom u_rom (.k(kidx), .w(wv));
        bfly_cmul u_mul (
            .clk(clk), .rst_n(rst_n), .bypass(kidx == '0),
            .x(u[m]), .w(wv), .p(yq[m]), .clipped(clip_v[m])
        );
    end

    assign out_valid = v3;
    assign ovfl      = v3 & (|clip_v);
    assign y0_re = yq[0].re;
    assign y0_im = yq[0].im;
    assign y1_re = yq[1].re;
    assign y1_im = yq[1].im;
    assign y2_re = yq[2].re;
    assign y2_im = yq[2].im;
    assign y3_re = yq[3].re;
    assign y3_im = yq[3].im;
endmodule

// File: rtl/radix4_bfly_checker.sv
// Module: temporal properties of radix4_bfly, attached by bind.
// Assumes: synchronous active-low reset; latency of three cycles.
module radix4_bfly_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [1:0] in_grp,
    input logic       out_valid,
    input logic       ovfl
);
    // R7: every accepted butterfly emerges three edges later.
    assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##3 out_valid);

    // R9: an idle input slot yields an idle output slot.
    assert_idle_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##3 !out_valid);

    // R6/R9: the overflow line only accompanies valid results.
    assert_ovfl_qualified_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovfl |-> out_valid);

    // R5: group 0 bypasses every multiplier, so it never clips.
    assert_grp0_no_clip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_grp == 2'd0) |-> ##3 !ovfl);

    // R8: an edge in reset leaves the outputs idle.
    assert_reset_idle_R8: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !ovfl));
endmodule

bind radix4_bfly radix4_bfly_checker u_radix4_bfly_checker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_grp(in_grp),
    .out_valid(out_valid), .ovfl(ovfl)
);

// File: tb/test_radix4_bfly.sv
`timescale 1ns/1ps
module test_radix4_bfly;
    localparam int NV = 11;
    // Columns: group, a_re, a_im, b_re, b_im, c_re, c_im, d_re, d_im
    localparam int STIM [NV][9] = '{
        '{0,  1000,     0,     0,     0,     0,     0,     0,     0},
        '{0,     0,     0,   400,     0,     0,     0,     0,     0},
        '{1,  1200,  -300,   450,   900,  -700,   100,  2000, -1500},
        '{2, -5000,  4000,  3000, -2000,  1000,  7000, -6000,   500},
        '{3,  9000, -9000,  -123,   456,  7890, -3210,  1111, -2222},
        '{1, -32768,-32768,-32768,-32768,-32768,-32768,-32768,-32768},
        '{3, 32767, 32767, 32767, 32767, 32767, 32767, 32767, 32767},
        '{2, 32767,-32768, 32767, 32767,-32768, 32767,-32768,-32768},
        '{0, 32767,-32768, 32767, 32767,-32768, 32767,-32768,-32768},
        '{3,    -3,    -5,    -7,    -1,    -9,   -11,   -13,    -3},
        '{1,    -1,    -1,     0,    -1,     1,     0,    -1,     1}
    };
    localparam int TWR [10] = '{32767, 30274, 23170, 12540, 0, -12540, -23170, -30274, -32767, -30274};
    localparam int TWI [10] = '{0, -12540, -23170, -30274, -32767, -30274, -23170, -12540, 0, 12540};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [1:0] in_grp = '0;
    logic signed [15:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0;
    logic signed [15:0] c_re = '0, c_im = '0, d_re = '0, d_im = '0;
    logic out_valid, ovfl;
    logic signed [15:0] yr [4];
    logic signed [15:0] yi [4];

    int nchk = 0;
    int nfail = 0;
    int er [4];
    int ei [4];
    int eov;

    always #10 clk = ~clk;

    radix4_bfly i_radix4_bfly (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_grp(in_grp),
        .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
        .c_re(c_re), .c_im(c_im), .d_re(d_re), .d_im(d_im),
        .out_valid(out_valid),
        .y0_re(yr[0]), .y0_im(yi[0]), .y1_re(yr[1]), .y1_im(yi[1]),
        .y2_re(yr[2]), .y2_im(yi[2]), .y3_re(yr[3]), .y3_im(yi[3]),
        .ovfl(ovfl)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive_row(input int r, input logic v);
        in_valid = v;
        in_grp = 2'(STIM[r][0]);
        a_re = 16'(STIM[r][1]); a_im = 16'(STIM[r][2]);
        b_re = 16'(STIM[r][3]); b_im = 16'(STIM[r][4]);
        c_re = 16'(STIM[r][5]); c_im = 16'(STIM[r][6]);
        d_re = 16'(STIM[r][7]); d_im = 16'(STIM[r][8]);
    endtask

    function automatic int hadd(input int x, input int y);
        return (x + y) >>> 1;
    endfunction

    function automatic int hsub(input int x, input int y);
        return (x - y) >>> 1;
    endfunction

    function automatic int sat16(input longint v, inout int flag);
        if (v > 32767) begin flag = 1; return 32767; end
        if (v < -32768) begin flag = 1; return -32768; end
        return int'(v);
    endfunction

    // Reference result of one table row, built from R1..R6.
    task automatic model(input int r);
        int spr, spi, smr, smi, tpr, tpi, tmr, tmi, g;
        g   = STIM[r][0];
        spr = hadd(STIM[r][1], STIM[r][5]); spi = hadd(STIM[r][2], STIM[r][6]);
        smr = hsub(STIM[r][1], STIM[r][5]); smi = hsub(STIM[r][2], STIM[r][6]);
        tpr = hadd(STIM[r][3], STIM[r][7]); tpi = hadd(STIM[r][4], STIM[r][8]);
        tmr = hsub(STIM[r][3], STIM[r][7]); tmi = hsub(STIM[r][4], STIM[r][8]);
        er[0] = hadd(spr, tpr); ei[0] = hadd(spi, tpi);
        er[2] = hsub(spr, tpr); ei[2] = hsub(spi, tpi);
        er[1] = hadd(smr, tmi); ei[1] = hsub(smi, tmr);
        er[3] = hsub(smr, tmi); ei[3] = hadd(smi, tmr);
        eov = 0;
        for (int m = 1; m < 4; m++) begin
            int k;
            longint pr, pi;
            k = m * g;
            if (k != 0) begin
                pr = longint'(er[m]) * TWR[k] - longint'(ei[m]) * TWI[k];
                pi = longint'(er[m]) * TWI[k] + longint'(ei[m]) * TWR[k];
                er[m] = sat16(pr >>> 15, eov);
                ei[m] = sat16(pi >>> 15, eov);
            end
        end
    endtask

    task automatic check_row(input int r);
        model(r);
        check("R7", $sformatf("row %0d out_valid", r), int'(out_valid), 1);
        check("R1", $sformatf("row %0d y0_re", r), int'(yr[0]), er[0]);
        check("R1", $sformatf("row %0d y0_im", r), int'(yi[0]), ei[0]);
        check("R3", $sformatf("row %0d y1_re", r), int'(yr[1]), er[1]);
        check("R3", $sformatf("row %0d y1_im", r), int'(yi[1]), ei[1]);
        check("R2", $sformatf("row %0d y2_re", r), int'(yr[2]), er[2]);
        check("R2", $sformatf("row %0d y2_im", r), int'(yi[2]), ei[2]);
        check("R5", $sformatf("row %0d y3_re", r), int'(yr[3]), er[3]);
        check("R5", $sformatf("row %0d y3_im", r), int'(yi[3]), ei[3]);
        check("R6", $sformatf("row %0d ovfl", r), int'(ovfl), eov);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: state after reset
        check("R8", "out_valid after reset", int'(out_valid), 0);
        check("R8", "ovfl after reset", int'(ovfl), 0);
        check("R8", "y0_re after reset", int'(yr[0]), 0);
        check("R8", "y3_im after reset", int'(yi[3]), 0);
        rst_n = 1'b1;

        // Table walk: one row per cycle, results checked three cycles later (R7)
        for (int t = 0; t < NV + 3; t++) begin
            @(negedge clk);
            if (t >= 3) check_row(t - 3);
            else check("R7", "out_valid before first result", int'(out_valid), 0);
            if (t < NV) drive_row(t, 1'b1);
            else in_valid = 1'b0;
        end

        // R1/R4: single impulse on a, every output a quarter of it
        drive_row(0, 1'b1);
        @(negedge clk); in_valid = 1'b0;
        repeat (2) @(negedge clk);
        check("R1", "impulse y0_re", int'(yr[0]), 250);
        check("R4", "impulse y2_re", int'(yr[2]), 250);
        check("R3", "impulse y1_im", int'(yi[1]), 0);

        // R3: impulse on b alone shows the rotation directions
        drive_row(1, 1'b1);
        @(negedge clk); in_valid = 1'b0;
        repeat (2) @(negedge clk);
        check("R3", "b impulse y1_im", int'(yi[1]), -100);
        check("R3", "b impulse y3_im", int'(yi[3]), 100);
        check("R2", "b impulse y2_re", int'(yr[2]), -100);

        // R6: saturating row with group 2 raises ovfl; same data at group 0 does not
        drive_row(7, 1'b1);
        @(negedge clk); drive_row(8, 1'b1);
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk);
        check("R6", "clip group 2 ovfl", int'(ovfl), 1);
        check("R6", "clip group 2 y1_im", int'(yi[1]), -32768);
        @(negedge clk);
        check("R5", "group 0 ovfl", int'(ovfl), 0);
        check("R5", "group 0 y1_re passes", int'(yr[1]), 32767);

        // R9: saturating data with in_valid low
        drive_row(7, 1'b0);
        repeat (3) @(negedge clk);
        check("R9", "idle out_valid", int'(out_valid), 0);
        check("R9", "idle ovfl", int'(ovfl), 0);

        // R8: reset in mid stream empties the pipeline
        drive_row(2, 1'b1);
        @(negedge clk); rst_n = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        check("R8", "mid reset out_valid", int'(out_valid), 0);
        check("R8", "mid reset y1_re", int'(yr[1]), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R8", "after mid reset out_valid", int'(out_valid), 0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule